// File: doc/BRIEF.md
# Interrupt Collector with Message-Write Delivery

The block gathers interrupt request lines from peripherals into one word of pending state, filters them through an enable mask and tells the processor about each enabled request by issuing one 32-bit write on an outbound master port. The target address and the write data of that message both come from a programmable delivery-target register: the address is the register with its five low bits forced to zero, and the data is those five low bits. The processor thus chooses where the message lands and which small code it carries.

Software reaches five word registers over a simple register bus with byte enables: a sticky record of enabled requests, the enable mask, a pending word that clears on any access, a control word whose bit 8 flags a bus error and blocks delivery, and the delivery-target word. Request lines pass through a synchroniser and an edge detector, so a line held high yields one event. Events that are waiting for the outbound port are kept one per source bit and issued lowest bit first.

Top module: `msg_irq_ctrl`

## Requirements
- R1: After reset the record, mask, pending and control words read zero, the target word reads CPU_BASE + 3, and msg_valid is low.
- R2: The word index is bus_addr[4:2]: 0 record, 1 mask, 2 pending, 3 control, 4 target. Read data appears on bus_rdata the cycle after the access and holds until the next read; indices 5 to 7 read zero and ignore writes.
- R3: A rising edge on a request line whose bit is in VALID_SRC (default 0x043F63A0: bits 5, 7, 8, 9, 13, 14, 16 to 21, 26) sets that pending bit whatever the mask holds; a line held high sets it once; lines outside VALID_SRC have no effect.
- R4: A read of the pending word returns its value and clears it; a write clears it; a new event in the same cycle as that access stays pending.
- R5: An event whose mask bit is set also sets its record bit; record bits stay set until reset and bus writes to the record word change nothing.
- R6: Each enabled event issues one write with msg_addr = target & ~0x1F and msg_data = target & 0x1F, taken from the target word when the message is launched.
- R7: While control bit 8 is set, enabled events update the record word but issue no message; a read of the control word returns bit 8 only, other bits reading zero.
- R8: msg_valid stays high with stable msg_addr and msg_data until msg_ready is seen high; a new message may follow in the next cycle.
- R9: Enabled events on several distinct bits arriving while the port is busy each produce one message.
- R10: Mask bits outside VALID_SRC are dropped on write and read back as zero.
- R11: bus_be[3] writes bits 31:24 (the byte at the lowest address), down to bus_be[0] for bits 7:0; bytes whose enable is low keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 32 | Request lines from peripherals, asynchronous |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address of the register |
| bus_be | input | 4 | Byte enables, bit 3 for the most significant byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| msg_valid | output | 1 | Outbound message write pending |
| msg_ready | input | 1 | Outbound port accepts the message |
| msg_addr | output | 32 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
The bench builds the block with CPU_BASE set to 0x12345000, so the reset target word 0x12345003 splits into a visible address of 0x12345000 and a message code of 3, and any slip in the address/data split shows up at once. SYNC_STAGES and VALID_SRC keep their defaults, which lets the bench drive both listed and unlisted request bits and time a bus access to land in the exact cycle an edge is detected. A behavioural model tracks every register, the pending-message set and the outbound port, and is compared with read data and the message port on every clock.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;

    typedef enum logic [2:0] {
        IDX_REC  = 3'd0,
        IDX_MASK = 3'd1,
        IDX_PEND = 3'd2,
        IDX_CTRL = 3'd3,
        IDX_TGT  = 3'd4
    } reg_idx_e;

    localparam int BUSERR_BIT = 8;   // control bit that blocks delivery
    localparam int CODE_W     = 5;   // low target bits carried as message data
    localparam int IDX_LSB    = 2;   // word index starts above byte offset
    localparam int IDX_W      = 3;

endpackage

// File: rtl/msg_irq_sync.sv
module msg_irq_sync #(
    parameter int                W       = 32,
    parameter int                STAGES  = 2,
    parameter logic [W-1:0]      VALID   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req_i,
    output logic [W-1:0] event_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.chain[0] = req_i;
        for (int s = 1; s < STAGES; s++) begin
            d.chain[s] = q.chain[s-1];
        end
        d.prev = q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // rising edge of the synchronised line, listed sources only
    assign event_o = q.chain[STAGES-1] & ~q.prev & VALID;

endmodule

// File: rtl/msg_irq_pick.sv
module msg_irq_pick #(
    parameter int W = 32
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] onehot_o,
    output logic         any_o
);

    // lowest set bit wins
    assign onehot_o = vec_i & (~vec_i + W'(1));
    assign any_o    = |vec_i;

endmodule

// File: rtl/msg_irq_deliver.sv
module msg_irq_deliver #(
    parameter int W      = 32,
    parameter int CODE_W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] enq_i,
    input  logic [W-1:0] tgt_i,
    input  logic         ready_i,
    output logic         valid_o,
    output logic [W-1:0] addr_o,
    output logic [W-1:0] data_o
);

    typedef struct packed {
        logic [W-1:0] send;
        logic         valid;
        logic [W-1:0] addr;
        logic [W-1:0] data;
    } dlv_t;

    dlv_t         q, d;
    logic [W-1:0] pick;
    logic         have;
    logic         free;

    msg_irq_pick #(.W(W)) u_pick (
        .vec_i    (q.send),
        .onehot_o (pick),
        .any_o    (have)
    );

    always_comb begin
        d    = q;
        free = !q.valid || ready_i;
        if (free) begin
            d.valid = have;
            if (have) begin
                d.addr = {tgt_i[W-1:CODE_W], {CODE_W{1'b0}}};
                d.data = {{(W-CODE_W){1'b0}}, tgt_i[CODE_W-1:0]};
            end
        end
        d.send = (q.send & ~(free ? pick : '0)) | enq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid_o = q.valid;
    assign addr_o  = q.addr;
    assign data_o  = q.data;

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o))); // R8

    AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick) && ((pick & ~q.send) == '0)); // R9

endmodule

// File: rtl/msg_irq_ctrl.sv
module msg_irq_ctrl
    import msg_irq_pkg::*;
#(
    parameter int                REG_W       = 32,
    parameter int                SYNC_STAGES = 2,
    parameter logic [REG_W-1:0]  VALID_SRC   = 32'h043F_63A0,
    parameter logic [REG_W-1:0]  CPU_BASE    = 32'hFFFA_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [REG_W-1:0]            irq_req,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [IDX_LSB+IDX_W-1:0]    bus_addr,
    input  logic [REG_W/8-1:0]          bus_be,
    input  logic [REG_W-1:0]            bus_wdata,
    output logic [REG_W-1:0]            bus_rdata,
    output logic                        msg_valid,
    input  logic                        msg_ready,
    output logic [REG_W-1:0]            msg_addr,
    output logic [REG_W-1:0]            msg_data
);

    localparam int               BE_W    = REG_W / 8;
    localparam logic [REG_W-1:0] TGT_RST = CPU_BASE + REG_W'(3);

    typedef struct packed {
        logic [REG_W-1:0] rec;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] pend;
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] tgt;
        logic [REG_W-1:0] rdata;
    } regs_t;

    regs_t            q, d;
    logic [REG_W-1:0] evt;
    logic [REG_W-1:0] enq;
    logic [REG_W-1:0] rd_mux;
    reg_idx_e         idx;
    logic             acc_rd, acc_wr, hit_pend;
    logic             unused_bits;

    function automatic logic [REG_W-1:0] merge_bytes(
        input logic [REG_W-1:0] old_v,
        input logic [REG_W-1:0] new_v,
        input logic [BE_W-1:0]  be
    );
        logic [REG_W-1:0] r;
        r = old_v;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return r;
    endfunction

    msg_irq_sync #(
        .W      (REG_W),
        .STAGES (SYNC_STAGES),
        .VALID  (VALID_SRC)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (irq_req),
        .event_o (evt)
    );

    always_comb begin
        idx      = reg_idx_e'(bus_addr[IDX_LSB +: IDX_W]);
        acc_rd   = bus_sel && !bus_wr;
        acc_wr   = bus_sel && bus_wr;
        hit_pend = bus_sel && (idx == IDX_PEND);

        case (idx)
            IDX_REC:  rd_mux = q.rec;
            IDX_MASK: rd_mux = q.mask;
            IDX_PEND: rd_mux = q.pend;
            IDX_CTRL: rd_mux = q.ctrl & (REG_W'(1) << BUSERR_BIT);
            IDX_TGT:  rd_mux = q.tgt;
            default:  rd_mux = '0;
        endcase

        d = q;
        if (acc_rd) d.rdata = rd_mux;

        // any access clears pending, fresh edges survive
        d.pend = (hit_pend ? '0 : q.pend) | evt;
        d.rec  = q.rec | (evt & q.mask);

        if (acc_wr) begin
            case (idx)
                IDX_MASK: d.mask = merge_bytes(q.mask, bus_wdata, bus_be) & VALID_SRC;
                IDX_CTRL: d.ctrl = merge_bytes(q.ctrl, bus_wdata, bus_be);
                IDX_TGT:  d.tgt  = merge_bytes(q.tgt,  bus_wdata, bus_be);
                default: ;
            endcase
        end

        enq = evt & q.mask & {REG_W{~q.ctrl[BUSERR_BIT]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.tgt <= TGT_RST;
        end else begin
            q <= d;
        end
    end

    msg_irq_deliver #(
        .W      (REG_W),
        .CODE_W (CODE_W)
    ) u_deliver (
        .clk     (clk),
        .rst_n   (rst_n),
        .enq_i   (enq),
        .tgt_i   (q.tgt),
        .ready_i (msg_ready),
        .valid_o (msg_valid),
        .addr_o  (msg_addr),
        .data_o  (msg_data)
    );

    assign bus_rdata   = q.rdata;
    assign unused_bits = ^{q.ctrl, bus_addr[IDX_LSB-1:0]};

    AST_REC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q.rec & $past(q.rec)) == $past(q.rec))); // R5

    AST_REC_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q.rec & ~$past(q.rec) & ~$past(q.mask)) == '0)); // R5

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_pend && (evt == '0)) |=> (q.pend == '0)); // R4

    AST_PEND_LISTED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend & ~VALID_SRC) == '0); // R3

endmodule

// File: tb/msg_irq_ctrl_tb.sv
module msg_irq_ctrl_tb;

    localparam logic [31:0] VALID = 32'h043F_63A0;
    localparam logic [31:0] BASE  = 32'h1234_5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_req = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msg_valid, msg_ready = 1'b1;
    logic [31:0] msg_addr, msg_data;

    int checks = 0, fails = 0, accepted = 0;
    logic [31:0] last_addr = '0, last_data = '0;

    always #2 clk = ~clk;

    msg_irq_ctrl #(.CPU_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // behavioural reference
    logic [31:0] m_s1, m_s2, m_prev, m_rec, m_mask, m_pend, m_ctrl, m_tgt, m_rd, m_send;
    logic        m_valid;
    logic [31:0] m_addr, m_data;
    logic [31:0] ev, wv, rv;
    int          ix;
    bit          free_now;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_rec <= 0; m_mask <= 0; m_pend <= 0;
            m_ctrl <= 0; m_tgt <= BASE + 3; m_rd <= 0; m_send <= 0;
            m_valid <= 0; m_addr <= 0; m_data <= 0;
        end else begin
            ev = m_s2 & ~m_prev & VALID;
            m_s1 <= irq_req; m_s2 <= m_s1; m_prev <= m_s2;
            ix = int'(bus_addr) / 4;
            case (ix)
                0: rv = m_rec;  1: rv = m_mask; 2: rv = m_pend;
                3: rv = m_ctrl & 32'h100; 4: rv = m_tgt; default: rv = 0;
            endcase
            if (bus_sel && !bus_wr) m_rd <= rv;
            m_pend <= ((bus_sel && ix == 2) ? 32'h0 : m_pend) | ev;
            m_rec  <= m_rec | (ev & m_mask);
            if (bus_sel && bus_wr) begin
                wv = (ix == 1) ? m_mask : (ix == 3) ? m_ctrl : m_tgt;
                for (int b = 0; b < 4; b++) if (bus_be[b]) wv[b*8 +: 8] = bus_wdata[b*8 +: 8];
                if (ix == 1) m_mask <= wv & VALID;
                if (ix == 3) m_ctrl <= wv;
                if (ix == 4) m_tgt  <= wv;
            end
            free_now = !m_valid || msg_ready;
            wv = m_send;
            if (free_now) begin
                m_valid <= (m_send != 0);
                if (m_send != 0) begin
                    m_addr <= m_tgt & ~32'h1F;
                    m_data <= m_tgt & 32'h1F;
                    for (int k = 0; k < 32; k++) if (m_send[k]) begin wv[k] = 1'b0; break; end
                end
            end
            m_send <= wv | (m_ctrl[8] ? 32'h0 : (ev & m_mask));
        end
    end

    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            accepted  <= accepted + 1;
            last_addr <= msg_addr;
            last_data <= msg_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // cycle compare against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 rdata", bus_rdata, m_rd);
            chk("R8 msg_valid", {31'b0, msg_valid}, {31'b0, m_valid});
            if (m_valid) begin
                chk("R6 msg_addr", msg_addr, m_addr);
                chk("R6 msg_data", msg_data, m_data);
            end
        end
    end

    task automatic rd(input int idx, output logic [31:0] v);
        bus_sel = 1; bus_wr = 0; bus_addr = 5'(idx * 4); bus_be = 0;
        @(negedge clk);
        bus_sel = 0;
        v = bus_rdata;
    endtask

    task automatic wr(input int idx, input logic [31:0] v, input logic [3:0] be);
        bus_sel = 1; bus_wr = 1; bus_addr = 5'(idx * 4); bus_be = be; bus_wdata = v;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog got=hung exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int base_cnt;
        idle(2);
        rst_n = 1;
        idle(1);
        // R1 reset state
        rd(0, v); chk("R1 rec", v, 0);
        rd(1, v); chk("R1 mask", v, 0);
        rd(2, v); chk("R1 pend", v, 0);
        rd(3, v); chk("R1 ctrl", v, 0);
        rd(4, v); chk("R1 tgt", v, 32'h1234_5003);
        chk("R1 msg_valid", {31'b0, msg_valid}, 0);

        // R10 mask limited to listed bits, R11 byte enables
        wr(1, 32'hFFFF_FFFF, 4'hF);
        rd(1, v); chk("R10 mask", v, 32'h043F_63A0);
        wr(1, 32'h0, 4'b0001);
        rd(1, v); chk("R11 low byte", v, 32'h043F_6300);
        wr(1, 32'hFFFF_FFFF, 4'hF);

        // R3 one event from a held line, R4 read clears, R6 message
        irq_req[5] = 1; idle(6);
        rd(2, v); chk("R3 pend bit5", v, 32'h20);
        rd(2, v); chk("R4 pend cleared", v, 0);
        chk("R6 count", 32'(accepted), 1);
        chk("R6 addr", last_addr, 32'h1234_5000);
        chk("R6 data", last_data, 32'h3);

        // R3 unlisted line ignored
        irq_req[0] = 1; idle(6);
        rd(2, v); chk("R3 unlisted", v, 0);
        chk("R3 no msg", 32'(accepted), 1);

        // R7 bus error blocks delivery, record still updated
        wr(3, 32'h0000_FFFF, 4'hF);
        rd(3, v); chk("R7 ctrl read", v, 32'h100);
        irq_req[7] = 1; idle(6);
        rd(0, v); chk("R7 rec bit7", v & 32'h80, 32'h80);
        chk("R7 no msg", 32'(accepted), 1);
        wr(3, 32'h0, 4'hF);
        irq_req = 0; idle(4);

        // R8 hold under back-pressure, R9 one message per bit
        wr(4, 32'hABCD_EF3F, 4'hF);
        rd(2, v);
        msg_ready = 0;
        base_cnt = accepted;
        irq_req[9] = 1; irq_req[16] = 1; irq_req[26] = 1;
        idle(7);
        chk("R8 valid held", {31'b0, msg_valid}, 1);
        chk("R8 addr", msg_addr, 32'hABCD_EF20);
        idle(3);
        chk("R8 data", msg_data, 32'h1F);
        msg_ready = 1; idle(6);
        chk("R9 three msgs", 32'(accepted - base_cnt), 3);
        irq_req = 0; idle(4);

        // R4 event in the same cycle as a pending read
        rd(2, v);
        irq_req[8] = 1;
        idle(2);
        rd(2, v); chk("R4 same cycle read", v, 0);
        rd(2, v); chk("R4 event kept", v, 32'h100);
        idle(4);

        // R5 record write ignored, R2 unmapped index
        rd(0, v); chk("R5 rec before", v, m_rec);
        wr(0, 32'h0, 4'hF);
        rd(0, v); chk("R5 rec write ignored", v, 32'h0401_03A0);
        rd(6, v); chk("R2 unmapped read", v, 0);
        wr(5, 32'h0, 4'hF);
        rd(1, v); chk("R2 unmapped write", v, 32'h043F_63A0);
        idle(2);
        finish_run();
    end

endmodule